// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a per-core tick timer controlled through a special-purpose register port. It holds a 32-bit up-counter and a mode word. The mode word carries a two-bit operating mode, an interrupt enable, a sticky pending flag and a 28-bit compare period. When the counter is running and its low 28 bits equal the period, the timer records a match. A match sets the pending flag. It also either wraps the count to zero, halts the counter, or lets it keep counting, depending on the mode. The interrupt output is high while the flag is pending and the enable is set.

Software reaches the two registers through a single address/data port. The high address bits select the timer group and the low bits select the register within it. The counter is started or stopped only when a write actually changes the mode field. Software can only clear the pending flag through a mode write, never set it. This lets a handler rewrite the period or enable without losing an event or raising a spurious one.

Top module: `tick_timer`

## Requirements
- R1: After reset the mode word reads 0 (mode disabled, enable 0, pending 0, period 0), the count reads 0 and `tick_irq` is low.
- R2: The port address is split as group = addr[15:11] and index = addr[10:0]. Group 10 index 0 is the mode word and group 10 index 1 is the count. Writes to any other address change nothing, and reads of any other address return 0.
- R3: The mode word layout is: bits [31:30] mode (00 disabled, 01 restart, 10 one-shot, 11 continuous), bit 29 interrupt enable, bit 28 pending, bits [27:0] period. While running, the count rises by one per clock.
- R4: A match is a running counter whose low 28 bits equal the period. A match sets pending, which is visible after the next clock edge.
- R5: In restart mode a match returns the count to 0 on the next edge.
- R6: In one-shot mode a match halts the counter at the period value, and no further match occurs.
- R7: In continuous mode the count keeps rising through a match.
- R8: A write that changes the mode field to disabled stops the counter. A write that changes it to any other mode starts the counter. A write that leaves the mode field unchanged does not start or stop the counter.
- R9: On a mode write, a 1 in the pending bit keeps the stored pending value, and a 0 clears it. A mode write can never set pending.
- R10: `tick_irq` is high exactly when pending and the interrupt enable are both set.
- R11: A match in the same cycle as a mode write that clears pending leaves pending set.
- R12: A count write loads the written value, with no increment in that cycle, and never starts the counter. The match test then uses the loaded value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spr_addr | input | 16 | Register address (group and index) |
| spr_we | input | 1 | Write strobe for the addressed register |
| spr_wdata | input | 32 | Write data |
| spr_rdata | output | 32 | Read data of the addressed register (combinational) |
| tick_irq | output | 1 | Timer interrupt request |

## Verification
The hardest states to reach from the ports are the collisions. One is a pending-clear write landing in the exact cycle of a match. Another is a count load that equals the period on a running counter. A third is rewriting one-shot mode after the counter has halted. The bench reaches these by counting edges from a known mode write so that the colliding write falls on the computed match cycle. It also sweeps every running mode against small periods and compares the count and pending flag on every cycle with closed-form values: k mod (P+1), min(k,P), and k.

// File: rtl/tt_pkg.sv
// Shared definitions for the tick timer: mode encoding and mode-word bit
// positions. Assumes a 32-bit data word with the control bits at the top.
package tt_pkg;
    typedef enum logic [1:0] {
        TT_OFF     = 2'b00,
        TT_RESTART = 2'b01,
        TT_ONESHOT = 2'b10,
        TT_CONT    = 2'b11
    } tt_mode_e;

    localparam int TT_MODE_HI = 31;
    localparam int TT_MODE_LO = 30;
    localparam int TT_IE_BIT  = 29;
    localparam int TT_PND_BIT = 28;
endpackage

// File: rtl/tt_decode.sv
// Address decoder: splits the register address into group and index and
// flags accesses to the mode word and to the count. Assumes GROUP_LSB < ADDR_W.
module tt_decode #(
    parameter int ADDR_W    = 16,
    parameter int GROUP_LSB = 11,
    parameter int GROUP     = 10,
    parameter int MODE_IDX  = 0,
    parameter int COUNT_IDX = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_mode,
    output logic              hit_count
);
    localparam int GRP_W = ADDR_W - GROUP_LSB;

    logic [GRP_W-1:0]     grp;
    logic [GROUP_LSB-1:0] idx;

    // split address into fields and compare against the timer's slots
    always_comb begin
        grp       = addr[ADDR_W-1:GROUP_LSB];
        idx       = addr[GROUP_LSB-1:0];
        hit_mode  = (grp == GRP_W'(GROUP)) && (idx == GROUP_LSB'(MODE_IDX));
        hit_count = (grp == GRP_W'(GROUP)) && (idx == GROUP_LSB'(COUNT_IDX));
    end
endmodule

// File: rtl/tt_ctrl.sv
// Mode register and run state: holds mode, enable, pending and period, and
// decides when the counter runs. Assumes the match input is already gated by
// the run state.
module tt_ctrl
    import tt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_mode,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                match,
    output tt_mode_e            mode,
    output logic                ie,
    output logic                pend,
    output logic [PERIOD_W-1:0] period,
    output logic                run
);
    tt_mode_e new_mode;
    logic     mode_change;
    logic     run_next;
    logic     pend_next;

    // next run state and pending value from writes and matches
    always_comb begin
        new_mode    = tt_mode_e'(wdata[TT_MODE_HI:TT_MODE_LO]);
        mode_change = wr_mode && (new_mode != mode);
        if (mode_change)
            run_next = (new_mode != TT_OFF);
        else if (match && mode == TT_ONESHOT)
            run_next = 1'b0;
        else
            run_next = run;
        pend_next = (pend && !(wr_mode && !wdata[TT_PND_BIT])) || match;
    end

    // register the mode word fields and run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= TT_OFF;
            ie     <= 1'b0;
            pend   <= 1'b0;
            period <= '0;
            run    <= 1'b0;
        end else begin
            if (wr_mode) begin
                mode   <= new_mode;
                ie     <= wdata[TT_IE_BIT];
                period <= wdata[PERIOD_W-1:0];
            end
            pend <= pend_next;
            run  <= run_next;
        end
    end
endmodule

// File: rtl/tt_counter.sv
// Count register with match detection and per-mode action on a match.
// Assumes a count write has priority over counting in the same cycle.
module tt_counter
    import tt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_count,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                run,
    input  tt_mode_e            mode,
    input  logic [PERIOD_W-1:0] period,
    output logic [DATA_W-1:0]   count,
    output logic                match
);
    logic [DATA_W-1:0] count_next;

    // match detection and next count
    always_comb begin
        match = run && (count[PERIOD_W-1:0] == period);
        if (wr_count)
            count_next = wdata;
        else if (match) begin
            case (mode)
                TT_RESTART: count_next = '0;
                TT_ONESHOT: count_next = count;
                default:    count_next = count + DATA_W'(1);
            endcase
        end else if (run)
            count_next = count + DATA_W'(1);
        else
            count_next = count;
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count_next;
    end
endmodule

// File: rtl/tick_timer.sv
// Tick timer top: decodes the register port, instantiates mode control and
// counter, builds read data and the interrupt. Assumes reads are
// combinational and writes take effect at the next clock edge.
module tick_timer
    import tt_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int PERIOD_W  = 28,
    parameter int GROUP_LSB = 11,
    parameter int GROUP     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] spr_addr,
    input  logic              spr_we,
    input  logic [DATA_W-1:0] spr_wdata,
    output logic [DATA_W-1:0] spr_rdata,
    output logic              tick_irq
);
    localparam int PAD_W = DATA_W - 4 - PERIOD_W;

    logic                hit_mode, hit_count;
    logic                wr_mode, wr_count;
    tt_mode_e            mode;
    logic                ie, pend, run, match;
    logic [PERIOD_W-1:0] period;
    logic [DATA_W-1:0]   count;
    logic [DATA_W-1:0]   mode_word;

    tt_decode #(
        .ADDR_W(ADDR_W), .GROUP_LSB(GROUP_LSB), .GROUP(GROUP),
        .MODE_IDX(0), .COUNT_IDX(1)
    ) u_dec (
        .addr(spr_addr), .hit_mode(hit_mode), .hit_count(hit_count)
    );

    assign wr_mode  = spr_we && hit_mode;
    assign wr_count = spr_we && hit_count;

    tt_ctrl #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wdata(spr_wdata),
        .match(match), .mode(mode), .ie(ie), .pend(pend),
        .period(period), .run(run)
    );

    tt_counter #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_count(wr_count), .wdata(spr_wdata),
        .run(run), .mode(mode), .period(period),
        .count(count), .match(match)
    );

    // assemble the mode word, zero-filling unused bits when the period is narrow
    generate
        if (PAD_W > 0) begin : g_pad
            assign mode_word = {mode, ie, pend, {PAD_W{1'b0}}, period};
        end else begin : g_nopad
            assign mode_word = {mode, ie, pend, period};
        end
    endgenerate

    // read multiplexer
    always_comb begin
        if (hit_mode)       spr_rdata = mode_word;
        else if (hit_count) spr_rdata = count;
        else                spr_rdata = '0;
    end

    assign tick_irq = pend && ie;
endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for the tick timer, bound to every instance of the top.
module tick_timer_chk
    import tt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_mode,
    input logic              wr_count,
    input logic [DATA_W-1:0] wdata,
    input tt_mode_e          mode,
    input logic              pend,
    input logic              run,
    input logic              match,
    input logic [DATA_W-1:0] count
);
    // R9
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && wdata[TT_PND_BIT] && !match |=> pend == $past(pend));
    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && !wdata[TT_PND_BIT] && !match |=> !pend);
    // R11
    match_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> pend);
    // R8
    same_mode_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && wdata[TT_MODE_HI:TT_MODE_LO] == mode && !match
        |=> run == $past(run));
    // R8
    stop_on_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode && wdata[TT_MODE_HI:TT_MODE_LO] == 2'b00 |=> !run);
    // R5
    restart_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match && mode == TT_RESTART && !wr_count |=> count == '0);
    // R6
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match && mode == TT_ONESHOT && !wr_mode |=> !run);
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_count |=> $stable(count));
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_count(wr_count),
    .wdata(spr_wdata), .mode(mode), .pend(pend), .run(run),
    .match(match), .count(count)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
    localparam logic [15:0] MODE_A = 16'h5000;
    localparam logic [15:0] CNT_A  = 16'h5001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] spr_addr = '0;
    logic        spr_we = 1'b0;
    logic [31:0] spr_wdata = '0;
    logic [31:0] spr_rdata;
    logic        tick_irq;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // reference state, updated once per clock by the stimulus tasks
    logic [1:0]  m_mode = 2'b00;
    logic        m_ie = 1'b0, m_pend = 1'b0, m_run = 1'b0;
    logic [27:0] m_per = '0;
    logic [31:0] m_cnt = '0;

    tick_timer uut (
        .clk(clk), .rst_n(rst_n), .spr_addr(spr_addr), .spr_we(spr_we),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata), .tick_irq(tick_irq)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mw(input logic [1:0] m, input logic ie,
                                       input logic pd, input logic [27:0] p);
        return {m, ie, pd, p};
    endfunction

    // one clock with the given port values; the reference advances alongside
    task automatic cyc(input logic we, input logic [15:0] a, input logic [31:0] d);
        logic        mt, wm, wc;
        logic [1:0]  nm;
        logic        n_run, n_pend;
        logic [31:0] n_cnt;
        spr_we = we; spr_addr = a; spr_wdata = d;
        wm = we && a == MODE_A;
        wc = we && a == CNT_A;
        mt = m_run && m_cnt[27:0] == m_per;
        nm = d[31:30];
        if (wm && nm != m_mode)            n_run = (nm != 2'b00);
        else if (mt && m_mode == 2'b10)    n_run = 1'b0;
        else                               n_run = m_run;
        if (wc)                            n_cnt = d;
        else if (mt && m_mode == 2'b01)    n_cnt = '0;
        else if (mt && m_mode == 2'b10)    n_cnt = m_cnt;
        else if (m_run)                    n_cnt = m_cnt + 1;
        else                               n_cnt = m_cnt;
        n_pend = (m_pend && !(wm && !d[28])) || mt;
        @(posedge clk);
        @(negedge clk);
        spr_we = 1'b0;
        m_run = n_run; m_cnt = n_cnt; m_pend = n_pend;
        if (wm) begin m_mode = nm; m_ie = d[29]; m_per = d[27:0]; end
    endtask

    task automatic verify(input string tag);
        spr_addr = MODE_A; #1;
        chk({tag, " mode word"}, spr_rdata, mw(m_mode, m_ie, m_pend, m_per));
        spr_addr = CNT_A; #1;
        chk({tag, " count"}, spr_rdata, m_cnt);
        chk({tag, " irq"}, {31'b0, tick_irq}, {31'b0, m_pend & m_ie});
    endtask

    task automatic read_at(input logic [15:0] a, output logic [31:0] v);
        spr_addr = a; #1; v = spr_rdata;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_at(MODE_A, v); chk("R1 mode word", v, 32'h0);
        read_at(CNT_A, v);  chk("R1 count", v, 32'h0);
        chk("R1 irq", {31'b0, tick_irq}, 32'h0);

        // R2 writes elsewhere are ignored, foreign reads give 0
        cyc(1'b1, 16'h4800, 32'hFFFF_FFFF);
        cyc(1'b1, 16'h5002, 32'hFFFF_FFFF);
        verify("R2 foreign write");
        read_at(16'h5002, v); chk("R2 foreign read", v, 32'h0);
        read_at(16'h4801, v); chk("R2 other group read", v, 32'h0);

        // R3 R5 R6 R7 R4 sweep over running modes and small periods
        for (int m = 1; m <= 3; m++) begin
            for (int p = 0; p <= 6; p++) begin
                cyc(1'b1, MODE_A, 32'h0);
                cyc(1'b1, CNT_A, 32'h0);
                cyc(1'b1, MODE_A, mw(2'(m), 1'b1, 1'b0, 28'(p)));
                for (int k = 0; k <= 2 * p + 5; k++) begin
                    logic [31:0] ec;
                    if (m == 1)      ec = 32'(k % (p + 1));
                    else if (m == 2) ec = (k < p) ? 32'(k) : 32'(p);
                    else             ec = 32'(k);
                    read_at(CNT_A, v);
                    chk(m == 1 ? "R5 restart count" : (m == 2 ? "R6 one-shot count" : "R7 continuous count"), v, ec);
                    read_at(MODE_A, v);
                    chk("R4 pending after match", {31'b0, v[28]}, {31'b0, k > p});
                    chk("R10 irq follows pending", {31'b0, tick_irq}, {31'b0, k > p});
                    verify("R3 model");
                    cyc(1'b0, MODE_A, 32'h0);
                end
            end
        end

        // one-shot halted at period 4 with pending set
        cyc(1'b1, MODE_A, 32'h0);
        cyc(1'b1, CNT_A, 32'h0);
        cyc(1'b1, MODE_A, mw(2'b10, 1'b0, 1'b0, 28'd4));
        repeat (8) cyc(1'b0, MODE_A, 32'h0);
        read_at(CNT_A, v); chk("R6 halted at period", v, 32'd4);
        // R10 pending with enable low keeps irq low
        read_at(MODE_A, v); chk("R10 pending set", {31'b0, v[28]}, 32'h1);
        chk("R10 irq masked", {31'b0, tick_irq}, 32'h0);
        // R9 write 1 keeps pending, enable now raises irq
        cyc(1'b1, MODE_A, mw(2'b10, 1'b1, 1'b1, 28'd4));
        read_at(MODE_A, v); chk("R9 pending kept", {31'b0, v[28]}, 32'h1);
        chk("R10 irq raised by enable", {31'b0, tick_irq}, 32'h1);
        // R8 rewriting the same mode does not restart the halted counter
        repeat (3) cyc(1'b0, MODE_A, 32'h0);
        read_at(CNT_A, v); chk("R8 same mode no restart", v, 32'd4);
        // R9 write 0 clears pending and irq
        cyc(1'b1, MODE_A, mw(2'b10, 1'b1, 1'b0, 28'd4));
        read_at(MODE_A, v); chk("R9 pending cleared", {31'b0, v[28]}, 32'h0);
        chk("R9 irq withdrawn", {31'b0, tick_irq}, 32'h0);
        // R9 writing 1 cannot set pending; R6 no further match
        cyc(1'b1, MODE_A, mw(2'b10, 1'b1, 1'b1, 28'd4));
        repeat (4) cyc(1'b0, MODE_A, 32'h0);
        read_at(MODE_A, v); chk("R9 write cannot set pending", {31'b0, v[28]}, 32'h0);
        verify("R6 halted");
        // R12 count write while halted does not start the counter
        cyc(1'b1, CNT_A, 32'd9);
        repeat (3) cyc(1'b0, MODE_A, 32'h0);
        read_at(CNT_A, v); chk("R12 load no start", v, 32'd9);
        // R8 mode change to restart starts it
        cyc(1'b1, MODE_A, mw(2'b01, 1'b1, 1'b0, 28'd20));
        repeat (2) cyc(1'b0, MODE_A, 32'h0);
        read_at(CNT_A, v); chk("R8 start on change", v, 32'd11);

        // R12 continuous, load count equal to period
        cyc(1'b1, MODE_A, mw(2'b11, 1'b1, 1'b0, 28'd20));
        cyc(1'b1, CNT_A, 32'd20);
        read_at(CNT_A, v); chk("R12 loaded no increment", v, 32'd20);
        read_at(MODE_A, v); chk("R12 not yet pending", {31'b0, v[28]}, 32'h0);
        cyc(1'b0, MODE_A, 32'h0);
        read_at(CNT_A, v); chk("R7 through match", v, 32'd21);
        read_at(MODE_A, v); chk("R12 match on loaded value", {31'b0, v[28]}, 32'h1);
        verify("R12 model");

        // R11 clearing write in the match cycle loses to the match
        cyc(1'b1, MODE_A, mw(2'b11, 1'b1, 1'b0, 28'd30));
        cyc(1'b1, CNT_A, 32'd27);
        repeat (3) cyc(1'b0, MODE_A, 32'h0);
        read_at(CNT_A, v); chk("R11 at match", v, 32'd30);
        cyc(1'b1, MODE_A, mw(2'b11, 1'b1, 1'b0, 28'd30));
        read_at(MODE_A, v); chk("R11 pending survives clear", {31'b0, v[28]}, 32'h1);
        verify("R11 model");

        // R8 change to disabled stops the counter
        cyc(1'b1, MODE_A, mw(2'b00, 1'b0, 1'b0, 28'd30));
        read_at(CNT_A, v);
        repeat (3) cyc(1'b0, MODE_A, 32'h0);
        begin
            logic [31:0] v2;
            read_at(CNT_A, v2); chk("R8 stopped", v2, v);
        end
        verify("R8 model");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule